// File: doc/BRIEF.md
# Burst SRAM Address Sequencer

This block is the address and control front end of a burstable synchronous cache SRAM. On every rising clock edge it samples an external base address, an active-low chip enable, two active-low address strobes (one from the processor, one from the cache controller), an active-low burst advance and two active-low byte write enables. From these it works out the access performed in the cycle that follows that edge. It drives the internal array address, flags whether an access takes place, says whether that access is a write, and reports when the device is deselected. The memory array, the data path and the output drivers sit outside this block.

The two strobes have different priority and write rules. The processor strobe, qualified by chip enable, always starts a read burst. The controller strobe starts a read or a write burst, or deselects the device when chip enable is high. Chip enable counts only in cycles that could load a base address. Between loads, the advance input either steps a 2-bit burst counter or holds it to insert a wait state. The counter drives only the two low address bits, using an interleaved order that wraps after four accesses.

A four-state machine names the kind of cycle being performed. `SEQ_IDLE` means deselected, with no access. `SEQ_START` is the first access of a new burst. `SEQ_STEP` is an access at an advanced address. `SEQ_STALL` is a wait-state access at an unchanged address. The transitions are: a processor load or a controller load goes to `SEQ_START` from any state. A controller strobe with chip enable high goes to `SEQ_IDLE`. An advance cycle goes to `SEQ_STEP`, and a hold cycle goes to `SEQ_STALL`, from any of the three access states. Advance and hold cycles leave `SEQ_IDLE` where it is. Synchronous reset goes to `SEQ_IDLE`.

Top module: `bsram_addr_seq`

## Requirements
- R1: When `pstrb_n` and `ce_n` are both 0 at a rising edge, the outputs after that edge show `acc_valid`=1, `acc_write`=0 and `arr_addr` equal to the sampled `ext_addr`, whatever `cstrb_n` and the write enables are; a burst in progress is abandoned.
- R2: When `cstrb_n`=0, `ce_n`=0 and `pstrb_n`=1, the external address is loaded and the access is valid; `acc_write` is 1 when either `wen_lo_n` or `wen_hi_n` is 0 and 0 when both are 1.
- R3: When `ce_n`=1 and `cstrb_n`=0, the outputs after the edge show `deselected`=1, `acc_valid`=0 and `acc_write`=0, whatever `pstrb_n` is; later advance or hold cycles keep the block deselected.
- R4: When `ce_n`=1 and `cstrb_n`=1, `pstrb_n` is ignored: no base address is loaded and the cycle is treated as an advance or hold cycle.
- R5: In advance and hold cycles `ce_n` has no effect: an active burst carries on with either value.
- R6: In an active burst, a cycle with `pstrb_n`/`ce_n` not loading, `cstrb_n`=1 and `adv_n`=0 steps the burst counter by one before the access; the access is a write when either write enable is 0.
- R7: In an active burst, the same kind of cycle with `adv_n`=1 holds `arr_addr` unchanged (wait state); the access stays valid and its write flag follows the write enables.
- R8: Bits 15..2 of `arr_addr` stay at the base value through a burst. Bits 1..0 equal base bits 1..0 XOR the counter (0,1,2,3), so after four accesses the address wraps to the base.
- R9: Synchronous reset (`rst`=1) gives `deselected`=1, `acc_valid`=0, `acc_write`=0 and `arr_addr`=0 after the edge; no access is flagged until the first load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ext_addr | input | 16 | External base address |
| ce_n | input | 1 | Chip enable, active low |
| pstrb_n | input | 1 | Processor address strobe, active low |
| cstrb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| wen_lo_n | input | 1 | Lower byte write enable, active low |
| wen_hi_n | input | 1 | Upper byte write enable, active low |
| arr_addr | output | 16 | Internal array address for the current access |
| acc_valid | output | 1 | An array access takes place this cycle |
| acc_write | output | 1 | The current access is a write |
| deselected | output | 1 | Device is deselected |

## Verification
A wrong burst counter or a wrong base register shows up at once on `arr_addr`, in the cycle after the edge that sampled the bad step, hold or load. It is never hidden, because every access exposes the full address. A wrong state, such as an access left active after a deselect or a missed load, shows on `acc_valid` and `deselected` at the next edge. A wrong strobe priority shows on `acc_write`, or on an address that did not change, in that same cycle. The reference model therefore compares all four outputs after every edge, across directed corner cases and a long stretch of mixed random commands.

// File: rtl/bsram_seq_pkg.sv
package bsram_seq_pkg;

    // Decoded meaning of one sampled set of control inputs
    typedef enum logic [2:0] {
        CMD_LOAD_PROC,   // processor strobe with chip enable: read burst
        CMD_LOAD_CTRL,   // controller strobe with chip enable: read or write burst
        CMD_DESELECT,    // controller strobe without chip enable
        CMD_ADVANCE,     // no load, step counter
        CMD_HOLD         // no load, wait state
    } seq_cmd_e;

    // Kind of cycle performed after the edge
    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_START,
        SEQ_STEP,
        SEQ_STALL
    } seq_state_e;

endpackage

// File: rtl/bsram_cmd_decode.sv
module bsram_cmd_decode
    import bsram_seq_pkg::*;
#(
    parameter int N_BYTE_EN = 2
) (
    input  logic                 ce_n,
    input  logic                 pstrb_n,
    input  logic                 cstrb_n,
    input  logic                 adv_n,
    input  logic [N_BYTE_EN-1:0] wen_n,
    output seq_cmd_e             cmd,
    output logic                 wr_req
);

    // Any byte lane enabled requests a write
    assign wr_req = ~(&wen_n);

    // Processor strobe wins when qualified by chip enable; controller
    // strobe is next; otherwise the burst continues or stalls.
    always_comb begin
        if (!pstrb_n && !ce_n) begin
            cmd = CMD_LOAD_PROC;
        end else if (!cstrb_n) begin
            cmd = ce_n ? CMD_DESELECT : CMD_LOAD_CTRL;
        end else begin
            cmd = adv_n ? CMD_HOLD : CMD_ADVANCE;
        end
    end

endmodule

// File: rtl/bsram_burst_ctr.sv
module bsram_burst_ctr #(
    parameter int ADDR_W     = 16,
    parameter int BURST_W    = 2,
    parameter bit INTERLEAVE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic [ADDR_W-1:0] arr_addr
);

    localparam int HI_W = ADDR_W - BURST_W;

    logic [ADDR_W-1:0]  base_q;
    logic [BURST_W-1:0] cnt_q;
    logic [BURST_W-1:0] low_bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            base_q <= ld_addr;
            cnt_q  <= '0;
        end else if (step) begin
            cnt_q  <= cnt_q + BURST_W'(1);
        end
    end

    generate
        if (INTERLEAVE) begin : g_xor_order
            assign low_bits = base_q[BURST_W-1:0] ^ cnt_q;
        end else begin : g_linear_order
            assign low_bits = base_q[BURST_W-1:0] + cnt_q;
        end
    endgenerate

    assign arr_addr = {base_q[ADDR_W-1:BURST_W], low_bits};

    // R8
    upper_bits_held_chk: assert property (@(posedge clk) disable iff (rst)
        (!load) |=> arr_addr[ADDR_W-1:BURST_W] == $past(arr_addr[ADDR_W-1:BURST_W]));

    // R7
    no_step_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !step) |=> $stable(arr_addr));

    // R8
    step_low_changes_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && step) |=> arr_addr[BURST_W-1:0] != $past(arr_addr[BURST_W-1:0]));

    localparam int UNUSED_HI = HI_W;

endmodule

// File: rtl/bsram_seq_fsm.sv
module bsram_seq_fsm
    import bsram_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  seq_cmd_e cmd,
    input  logic     wr_req,
    output logic     ctr_load,
    output logic     ctr_step,
    output logic     acc_valid,
    output logic     acc_write,
    output logic     deselected
);

    seq_state_e state_q;
    seq_state_e state_d;
    logic       wr_d;
    logic       wr_q;
    logic       active;

    assign active = (state_q != SEQ_IDLE);

    // Next-state decision
    always_comb begin
        state_d  = state_q;
        wr_d     = 1'b0;
        ctr_load = 1'b0;
        ctr_step = 1'b0;
        unique case (cmd)
            CMD_LOAD_PROC: begin
                state_d  = SEQ_START;
                ctr_load = 1'b1;
            end
            CMD_LOAD_CTRL: begin
                state_d  = SEQ_START;
                wr_d     = wr_req;
                ctr_load = 1'b1;
            end
            CMD_DESELECT: begin
                state_d  = SEQ_IDLE;
            end
            CMD_ADVANCE: begin
                if (active) begin
                    state_d  = SEQ_STEP;
                    wr_d     = wr_req;
                    ctr_step = 1'b1;
                end
            end
            CMD_HOLD: begin
                if (active) begin
                    state_d = SEQ_STALL;
                    wr_d    = wr_req;
                end
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q <= 1'b0;
        end else begin
            wr_q <= wr_d;
        end
    end

    assign acc_valid  = active;
    assign acc_write  = wr_q;
    assign deselected = (state_q == SEQ_IDLE);

    // R3
    idle_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_IDLE && (cmd == CMD_ADVANCE || cmd == CMD_HOLD)) |=> state_q == SEQ_IDLE);

    // R9
    idle_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_IDLE) |-> !acc_write);

    // R1
    proc_load_read_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_LOAD_PROC) |=> (state_q == SEQ_START && !acc_write));

endmodule

// File: rtl/bsram_addr_seq.sv
module bsram_addr_seq
    import bsram_seq_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int BURST_W    = 2,
    parameter bit INTERLEAVE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              ce_n,
    input  logic              pstrb_n,
    input  logic              cstrb_n,
    input  logic              adv_n,
    input  logic              wen_lo_n,
    input  logic              wen_hi_n,
    output logic [ADDR_W-1:0] arr_addr,
    output logic              acc_valid,
    output logic              acc_write,
    output logic              deselected
);

    localparam int N_BYTE_EN = 2;

    seq_cmd_e             cmd;
    logic                 wr_req;
    logic                 ctr_load;
    logic                 ctr_step;
    logic [N_BYTE_EN-1:0] wen_n;

    assign wen_n = {wen_hi_n, wen_lo_n};

    bsram_cmd_decode #(
        .N_BYTE_EN (N_BYTE_EN)
    ) u_decode (
        .ce_n    (ce_n),
        .pstrb_n (pstrb_n),
        .cstrb_n (cstrb_n),
        .adv_n   (adv_n),
        .wen_n   (wen_n),
        .cmd     (cmd),
        .wr_req  (wr_req)
    );

    bsram_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .wr_req     (wr_req),
        .ctr_load   (ctr_load),
        .ctr_step   (ctr_step),
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .deselected (deselected)
    );

    bsram_burst_ctr #(
        .ADDR_W     (ADDR_W),
        .BURST_W    (BURST_W),
        .INTERLEAVE (INTERLEAVE)
    ) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (ctr_load),
        .step     (ctr_step),
        .ld_addr  (ext_addr),
        .arr_addr (arr_addr)
    );

    // R1
    proc_strobe_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!pstrb_n && !ce_n) |=> (acc_valid && !acc_write && arr_addr == $past(ext_addr)));

    // R2
    ctrl_strobe_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!cstrb_n && pstrb_n && !ce_n) |=>
            (acc_valid && arr_addr == $past(ext_addr) && acc_write == $past(!(wen_lo_n && wen_hi_n))));

    // R3
    deselect_chk: assert property (@(posedge clk) disable iff (rst)
        (ce_n && !cstrb_n) |=> (deselected && !acc_valid && !acc_write));

    // R4
    proc_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (ce_n && cstrb_n && !pstrb_n && !acc_valid) |=> !acc_valid);

    // R5
    ce_dont_care_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && cstrb_n && ce_n) |=> acc_valid);

    // R7
    wait_state_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && cstrb_n && (pstrb_n || ce_n) && adv_n) |=> (acc_valid && $stable(arr_addr)));

    // R9
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (deselected && !acc_valid && !acc_write && arr_addr == '0));

endmodule

// File: tb/bsram_addr_seq_tb.sv
`timescale 1ns/1ps
module bsram_addr_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] ext_addr;
    logic        ce_n, pstrb_n, cstrb_n, adv_n, wen_lo_n, wen_hi_n;
    logic [15:0] arr_addr;
    logic        acc_valid, acc_write, deselected;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    // Reference model state
    int m_base   = 0;
    int m_cnt    = 0;
    bit m_active = 1'b0;
    bit m_write  = 1'b0;

    always #2.5 clk = ~clk;

    bsram_addr_seq dut_i (
        .clk        (clk),
        .rst        (rst),
        .ext_addr   (ext_addr),
        .ce_n       (ce_n),
        .pstrb_n    (pstrb_n),
        .cstrb_n    (cstrb_n),
        .adv_n      (adv_n),
        .wen_lo_n   (wen_lo_n),
        .wen_hi_n   (wen_hi_n),
        .arr_addr   (arr_addr),
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .deselected (deselected)
    );

    function automatic int exp_addr();
        return (m_base & 16'hFFFC) | ((m_base & 3) ^ (m_cnt % 4));
    endfunction

    task automatic cyc(input bit r, input int a, input bit ce, input bit ps, input bit cs,
                       input bit av, input bit wl, input bit wh, input string tag);
        int ea;
        rst = r; ext_addr = a[15:0]; ce_n = ce; pstrb_n = ps; cstrb_n = cs;
        adv_n = av; wen_lo_n = wl; wen_hi_n = wh;
        if (r) begin
            m_base = 0; m_cnt = 0; m_active = 0; m_write = 0;
        end else if (!ps && !ce) begin
            m_base = a & 16'hFFFF; m_cnt = 0; m_active = 1; m_write = 0;
        end else if (!cs) begin
            if (ce) begin
                m_active = 0; m_write = 0;
            end else begin
                m_base = a & 16'hFFFF; m_cnt = 0; m_active = 1; m_write = !(wl && wh);
            end
        end else if (m_active) begin
            if (!av) m_cnt = (m_cnt + 1) % 4;
            m_write = !(wl && wh);
        end else begin
            m_write = 0;
        end
        @(posedge clk);
        @(negedge clk);
        ea = exp_addr();
        checks++;
        if (arr_addr !== ea[15:0] || acc_valid !== m_active || acc_write !== m_write ||
            deselected !== !m_active) begin
            failures++;
            $display("FAIL %s: addr=%h valid=%b write=%b desel=%b expected addr=%h valid=%b write=%b desel=%b",
                     tag, arr_addr, acc_valid, acc_write, deselected,
                     ea[15:0], m_active, m_write, !m_active);
        end
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R9 reset state
        cyc(1, 16'h5555, 1, 1, 1, 1, 1, 1, "R9");
        cyc(1, 16'h5555, 1, 1, 1, 1, 1, 1, "R9");
        // R9 advance while deselected flags nothing
        cyc(0, 16'h0000, 0, 1, 1, 0, 0, 0, "R9");
        // R1 processor load is a read despite controller strobe and write enables
        cyc(0, 16'h1236, 0, 0, 0, 1, 0, 0, "R1");
        // R6 / R8 interleaved steps: 1237, 1234, 1235, then wrap to 1236
        cyc(0, 16'hFFFF, 0, 1, 1, 0, 1, 1, "R6");
        cyc(0, 16'hFFFF, 0, 1, 1, 0, 1, 1, "R8");
        cyc(0, 16'hFFFF, 0, 1, 1, 0, 1, 1, "R8");
        cyc(0, 16'hFFFF, 0, 1, 1, 0, 1, 1, "R8");
        // R7 wait state, R5 chip enable ignored
        cyc(0, 16'h0000, 1, 1, 1, 1, 1, 1, "R7");
        cyc(0, 16'h0000, 1, 1, 1, 0, 1, 1, "R5");
        // R2 controller write load, lower lane
        cyc(0, 16'hABCD, 0, 1, 0, 1, 0, 1, "R2");
        cyc(0, 16'h0000, 0, 1, 1, 0, 1, 0, "R6");
        cyc(0, 16'h0000, 0, 1, 1, 1, 1, 1, "R7");
        // R2 controller read load
        cyc(0, 16'h4441, 0, 1, 0, 0, 1, 1, "R2");
        // R4 processor strobe without chip enable is ignored
        cyc(0, 16'h9999, 1, 0, 1, 1, 1, 1, "R4");
        cyc(0, 16'h9998, 1, 0, 1, 0, 1, 1, "R4");
        // R3 deselect regardless of processor strobe, then stays deselected
        cyc(0, 16'h7777, 1, 0, 0, 1, 0, 0, "R3");
        cyc(0, 16'h7777, 0, 1, 1, 0, 0, 0, "R3");
        cyc(0, 16'h7777, 1, 0, 1, 1, 1, 1, "R4");
        // R1 processor load interrupts a burst
        cyc(0, 16'h2002, 0, 1, 0, 1, 0, 0, "R2");
        cyc(0, 16'h2002, 0, 1, 1, 0, 0, 0, "R6");
        cyc(0, 16'h3C03, 0, 0, 1, 0, 1, 1, "R1");
        // R7 processor two-cycle write: load, then hold with write enable
        cyc(0, 16'h3C03, 0, 1, 1, 1, 1, 0, "R7");
        // R9 reset in the middle of a burst
        cyc(1, 16'h3C03, 0, 0, 1, 0, 1, 1, "R9");
        // R6 mixed random traffic
        for (int i = 0; i < 400; i++) begin
            int a = $urandom_range(0, 65535);
            int sel = $urandom_range(0, 9);
            bit ce = ($urandom_range(0, 4) == 0);
            bit wl = $urandom_range(0, 1);
            bit wh = $urandom_range(0, 1);
            bit av = $urandom_range(0, 1);
            bit ps = (sel != 0);
            bit cs = (sel != 1);
            cyc(0, a, ce, ps, cs, av, wl, wh, "R6");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule